// File: doc/BRIEF.md
# Scaled Fixed-Point Timestamp Counter

This block produces a free-running 64-bit system timestamp for timers elsewhere in the chip. Those timers consume the count rather than a raw clock. The count is the integer part of an 88-bit accumulator in 64.24 fixed point. On every clock cycle where the counter runs, an increment is added to the accumulator. The increment is either a programmable 32-bit rate or exactly one integer unit. A rate below one unit slows the timestamp and a rate above it speeds the timestamp up, while the fraction preserves long-term accuracy.

Software controls the block through its ports. It can load a new rate, turn the counter on and off, and choose between the programmed rate and the fixed unity rate. It can also overwrite either 32-bit half of the visible count independently. Each such overwrite raises a single-cycle change pulse. Downstream consumers use that pulse to recompute any deadlines they derived from the old count.

Top module: `fxp_ts_counter`

## Requirements
- R1: A synchronous active-low reset clears the count and the fraction to zero, drives the change pulse low, and sets the rate register to 0x01000000, which is exactly one count per tick.
- R2: With `run_en` and `scale_en` high and no count write, each clock adds the 32-bit rate register to the 88-bit accumulator. `count_q` is accumulator bits [87:24].
- R3: With `run_en` high and `scale_en` low, each clock advances `count_q` by exactly one whatever the rate register holds.
- R4: While `run_en` is low and no count write occurs, `count_q` keeps its value.
- R5: A carry out of the 24-bit fraction reaches `count_q` in the same clock, and the count wraps from 2^64-1 to 0.
- R6: `wr_lo` replaces count bits [31:0] and `wr_hi` replaces count bits [63:32]. The half not written keeps its value from the cycle of the write. Both strobes in one cycle replace both halves.
- R7: A count write clears the 24 fraction bits.
- R8: `count_chg` is high for exactly the one cycle after each cycle with a count write (the cycle the new count is visible), and low otherwise.
- R9: A count write takes priority over the tick increment in the same cycle.
- R10: A rate loaded with `scale_ld` is used from the next tick onward. A tick in the load cycle still uses the previous rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; each edge with `run_en` high is a tick |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counter runs when high |
| scale_en | input | 1 | High: add the rate register per tick; low: add one unit |
| scale_ld | input | 1 | Load strobe for the rate register |
| scale_ld_val | input | 32 | New rate, 8.24 fixed point |
| wr_lo | input | 1 | Write strobe for count bits [31:0] |
| wr_lo_val | input | 32 | Data for the low half |
| wr_hi | input | 1 | Write strobe for count bits [63:32] |
| wr_hi_val | input | 32 | Data for the high half |
| count_q | output | 64 | Integer part of the accumulator |
| count_chg | output | 1 | One-cycle pulse after a count write |

## Verification
Most state errors in this block reach the ports within a few ticks. A wrong carry between adder segments or a wrong increment select shows up on `count_q` on the first tick that exercises it. A fraction left uncleared after a write, or a rate taking effect one tick early, is more subtle. It corrupts only the fraction, so `count_q` may look right for up to 2^24/rate ticks. The bench therefore chooses half-unit rates so that any such fraction error crosses into the integer within one or two ticks. It compares every cycle against a bit-exact 88-bit model.

// File: rtl/fxp_ts_pkg.sv
// Package: shared widths and constants for the fixed-point timestamp counter.
// Assumes the accumulator is the integer width plus the fraction width.
package fxp_ts_pkg;
    localparam int INT_W   = 64;
    localparam int FRAC_W  = 24;
    localparam int ACC_W   = INT_W + FRAC_W;
    localparam int RATE_W  = 32;
    localparam int HALF_W  = 32;
    localparam int NHALF   = INT_W / HALF_W;
    localparam int SEG_W   = 22;
    localparam logic [RATE_W-1:0] UNITY_RATE = RATE_W'(1) << FRAC_W;

    typedef logic [INT_W-1:0] count_t;
    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/fxp_ts_rate_sel.sv
// Module: holds the programmable rate register and selects the per-tick increment.
// Assumes the loaded rate is used from the edge after the load (the register
// output is sampled by the adder before the load lands).
module fxp_ts_rate_sel #(
    parameter int RATE_W = fxp_ts_pkg::RATE_W,
    parameter logic [RATE_W-1:0] UNITY = fxp_ts_pkg::UNITY_RATE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [RATE_W-1:0] ld_val,
    input  logic              scale_en,
    output logic [RATE_W-1:0] inc
);
    logic [RATE_W-1:0] rate_q;

    // Rate register: reset to unity, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= UNITY;
        end else if (ld) begin
            rate_q <= ld_val;
        end
    end

    // Increment select: programmed rate or one integer unit.
    always_comb begin
        inc = scale_en ? rate_q : UNITY;
    end
endmodule

// File: rtl/fxp_ts_seg_adder.sv
// Module: wide modular adder built from equal segments with a rippled carry.
// Assumes W is a multiple of SEG_W; the carry out of the top segment is dropped,
// which gives wrap-around at 2^W.
module fxp_ts_seg_adder #(
    parameter int W     = fxp_ts_pkg::ACC_W,
    parameter int SEG_W = fxp_ts_pkg::SEG_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int NSEG = W / SEG_W;

    logic [NSEG-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g < NSEG - 1) begin : g_mid
            logic [SEG_W:0] part;
            // Segment add with carry out to the next segment.
            always_comb begin
                part = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]}
                     + {{SEG_W{1'b0}}, carry[g]};
            end
            assign sum[g*SEG_W +: SEG_W] = part[SEG_W-1:0];
            assign carry[g+1]            = part[SEG_W];
        end else begin : g_top
            // Top segment: carry out discarded for modular wrap.
            always_comb begin
                sum[g*SEG_W +: SEG_W] = a[g*SEG_W +: SEG_W] + b[g*SEG_W +: SEG_W]
                                      + {{(SEG_W-1){1'b0}}, carry[g]};
            end
        end
    end
endmodule

// File: rtl/fxp_ts_half_merge.sv
// Module: merges per-half write data into the current integer count.
// Assumes half index 0 is the least significant half.
module fxp_ts_half_merge #(
    parameter int HALF_W = fxp_ts_pkg::HALF_W,
    parameter int NHALF  = fxp_ts_pkg::NHALF
) (
    input  logic [NHALF*HALF_W-1:0]         cur,
    input  logic [NHALF-1:0]                wr,
    input  logic [NHALF-1:0][HALF_W-1:0]    wr_val,
    output logic [NHALF*HALF_W-1:0]         merged,
    output logic                            any_wr
);
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        // Per-half select: new data when strobed, else current value.
        always_comb begin
            merged[h*HALF_W +: HALF_W] = wr[h] ? wr_val[h] : cur[h*HALF_W +: HALF_W];
        end
    end

    // Any-write flag for the priority mux and the change pulse.
    always_comb begin
        any_wr = |wr;
    end
endmodule

// File: rtl/fxp_ts_counter.sv
// Module: top of the scaled fixed-point timestamp counter.
// Keeps an accumulator of integer plus fraction bits, adds the selected
// increment each running cycle, lets either integer half be overwritten
// (clearing the fraction, priority over the tick) and pulses count_chg
// in the cycle the written value appears. Assumes a single clock domain.
module fxp_ts_counter
    import fxp_ts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        scale_en,
    input  logic        scale_ld,
    input  logic [31:0] scale_ld_val,
    input  logic        wr_lo,
    input  logic [31:0] wr_lo_val,
    input  logic        wr_hi,
    input  logic [31:0] wr_hi_val,
    output logic [63:0] count_q,
    output logic        count_chg
);
    acc_t                          acc_q;
    acc_t                          acc_sum;
    acc_t                          acc_nxt;
    rate_t                         inc;
    count_t                        merged;
    logic                          any_wr;
    logic [NHALF-1:0]              wr_vec;
    logic [NHALF-1:0][HALF_W-1:0]  wr_data;

    // Pack the two half-write ports into indexed arrays.
    always_comb begin
        wr_vec     = {wr_hi, wr_lo};
        wr_data[0] = wr_lo_val;
        wr_data[1] = wr_hi_val;
    end

    fxp_ts_rate_sel #(
        .RATE_W (RATE_W),
        .UNITY  (UNITY_RATE)
    ) rate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (scale_ld),
        .ld_val   (scale_ld_val),
        .scale_en (scale_en),
        .inc      (inc)
    );

    fxp_ts_seg_adder #(
        .W     (ACC_W),
        .SEG_W (SEG_W)
    ) add_i (
        .a   (acc_q),
        .b   ({{(ACC_W-RATE_W){1'b0}}, inc}),
        .sum (acc_sum)
    );

    fxp_ts_half_merge #(
        .HALF_W (HALF_W),
        .NHALF  (NHALF)
    ) merge_i (
        .cur    (acc_q[ACC_W-1:FRAC_W]),
        .wr     (wr_vec),
        .wr_val (wr_data),
        .merged (merged),
        .any_wr (any_wr)
    );

    // Next accumulator: write beats tick, tick beats hold.
    always_comb begin
        if (any_wr) begin
            acc_nxt = {merged, {FRAC_W{1'b0}}};
        end else if (run_en) begin
            acc_nxt = acc_sum;
        end else begin
            acc_nxt = acc_q;
        end
    end

    // Accumulator and change-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            count_chg <= 1'b0;
        end else begin
            acc_q     <= acc_nxt;
            count_chg <= any_wr;
        end
    end

    assign count_q = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/fxp_ts_counter_chk.sv
// Module: assertion checker bound to fxp_ts_counter; observes ports only.
module fxp_ts_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_en,
    input logic        scale_en,
    input logic        wr_lo,
    input logic [31:0] wr_lo_val,
    input logic        wr_hi,
    input logic [31:0] wr_hi_val,
    input logic [63:0] count_q,
    input logic        count_chg
);
    // R1: reset clears count and pulse.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (count_q == 64'd0 && !count_chg));

    // R4: no run and no write holds the count.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_lo && !wr_hi) |=> $stable(count_q));

    // R3: unity ticks add one.
    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !scale_en && !wr_lo && !wr_hi) |=> (count_q == $past(count_q) + 64'd1));

    // R2: a scaled tick moves the integer by at most 256.
    a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && scale_en && !wr_lo && !wr_hi) |=> ((count_q - $past(count_q)) <= 64'd256));

    // R6: low-half write keeps the high half.
    a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (count_q[31:0] == $past(wr_lo_val)
                               && count_q[63:32] == $past(count_q[63:32])));

    // R6: high-half write keeps the low half.
    a_r6_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (count_q[63:32] == $past(wr_hi_val)
                               && count_q[31:0] == $past(count_q[31:0])));

    // R8: write cycle is followed by a pulse.
    a_r8_pulse_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> count_chg);

    // R8: no write, no pulse.
    a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> !count_chg);
endmodule

bind fxp_ts_counter fxp_ts_counter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .scale_en  (scale_en),
    .wr_lo     (wr_lo),
    .wr_lo_val (wr_lo_val),
    .wr_hi     (wr_hi),
    .wr_hi_val (wr_hi_val),
    .count_q   (count_q),
    .count_chg (count_chg)
);

// File: tb/fxp_ts_counter_tb_top.sv
// Bench: directed corners plus seeded random stimulus against an 88-bit model.
module fxp_ts_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        scale_en = 1'b0;
    logic        scale_ld = 1'b0;
    logic [31:0] scale_ld_val = '0;
    logic        wr_lo = 1'b0;
    logic [31:0] wr_lo_val = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_hi_val = '0;
    logic [63:0] count_q;
    logic        count_chg;

    int unsigned n_total = 0;
    int unsigned n_fail  = 0;
    logic [87:0] m_acc;
    logic [31:0] m_rate;
    logic        m_chg;

    always #5 clk = ~clk;

    fxp_ts_counter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .scale_en     (scale_en),
        .scale_ld     (scale_ld),
        .scale_ld_val (scale_ld_val),
        .wr_lo        (wr_lo),
        .wr_lo_val    (wr_lo_val),
        .wr_hi        (wr_hi),
        .wr_hi_val    (wr_hi_val),
        .count_q      (count_q),
        .count_chg    (count_chg)
    );

    // Model of one clock edge, written from the requirements.
    function automatic logic [87:0] next_acc(logic [87:0] acc, logic [31:0] rate);
        logic [63:0] ip;
        if (!rst_n) return 88'd0;                                   // R1
        if (wr_lo || wr_hi) begin                                   // R9
            ip = acc[87:24];
            if (wr_lo) ip[31:0]  = wr_lo_val;                       // R6
            if (wr_hi) ip[63:32] = wr_hi_val;
            return {ip, 24'd0};                                     // R7
        end
        if (run_en)
            return acc + (scale_en ? {56'd0, rate} : 88'h1000000);  // R2 R3 R5
        return acc;                                                 // R4
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    // One cycle: update model, cross the edge, compare at the falling edge.
    task automatic cycle(string req);
        m_acc  = next_acc(m_acc, m_rate);
        m_chg  = rst_n && (wr_lo || wr_hi);                          // R8
        m_rate = !rst_n ? 32'h0100_0000 : (scale_ld ? scale_ld_val : m_rate); // R10
        @(posedge clk);
        @(negedge clk);
        check(req, count_q, m_acc[87:24]);
        check({req, " R8 pulse"}, {63'd0, count_chg}, {63'd0, m_chg});
        scale_ld = 1'b0;
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    task automatic write_count(logic lo, logic hi, logic [63:0] v, string req);
        wr_lo = lo; wr_hi = hi; wr_lo_val = v[31:0]; wr_hi_val = v[63:32];
        cycle(req);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_acc = '0; m_rate = 32'h0100_0000; m_chg = 1'b0;
        void'($urandom(32'h0BAD_5EED));
        for (int i = 0; i < 3; i++) cycle("R1 reset");
        rst_n = 1'b1;

        // R1: reset rate is unity when scaling is selected.
        run_en = 1'b1; scale_en = 1'b1;
        for (int i = 0; i < 4; i++) cycle("R1 unity reset rate");
        check("R1 four unity ticks", count_q, 64'd4);

        // R3: loaded rate ignored while scaling is off.
        scale_en = 1'b0; scale_ld = 1'b1; scale_ld_val = 32'h0080_0000;
        for (int i = 0; i < 4; i++) cycle("R3 unscaled");

        // R2: half rate advances every second tick.
        scale_en = 1'b1;
        for (int i = 0; i < 5; i++) cycle("R2 half rate");

        // R10: load during a tick; this tick uses the old rate.
        scale_ld = 1'b1; scale_ld_val = 32'h0300_0000;
        cycle("R10 old rate in load cycle");
        cycle("R10 new rate next tick");

        // R4: hold while stopped.
        run_en = 1'b0;
        for (int i = 0; i < 3; i++) cycle("R4 hold");

        // R9 R6: half writes while running.
        run_en = 1'b1;
        write_count(1'b1, 1'b0, 64'h0000_0000_1234_5678, "R9 R6 low write");
        write_count(1'b0, 1'b1, 64'hCAFE_0001_0000_0000, "R6 high write");
        write_count(1'b1, 1'b1, 64'h0000_0000_0000_0064, "R6 both halves");

        // R7: fraction cleared by a write.
        scale_ld = 1'b1; scale_ld_val = 32'h0080_0000;
        cycle("R7 load half rate");
        write_count(1'b1, 1'b0, 64'd100, "R7 write after half tick");
        cycle("R7 fraction cleared");
        check("R7 count after one half tick", count_q, 64'd100);

        // R5: carry and wrap.
        scale_en = 1'b0;
        write_count(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 set max");
        cycle("R5 wrap");
        check("R5 wrapped to zero", count_q, 64'd0);
        scale_en = 1'b1; scale_ld = 1'b1; scale_ld_val = 32'hFFFF_FFFF;
        cycle("R5 load max rate");
        write_count(1'b1, 1'b1, 64'd0, "R5 clear");
        cycle("R5 max rate tick");
        cycle("R5 fraction carry");
        check("R5 carry total", count_q, 64'd511);

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            rst_n    = (r[7:0] != 8'd0);
            run_en   = r[8] | r[9];
            scale_en = r[10];
            scale_ld = (r[14:11] == 4'd0);
            case (r[17:16])
                2'd0: scale_ld_val = $urandom;
                2'd1: scale_ld_val = 32'h0100_0000;
                2'd2: scale_ld_val = 32'h0080_0001;
                default: scale_ld_val = 32'hFFFF_FFFF;
            endcase
            wr_lo = (r[21:18] == 4'd0);
            wr_hi = (r[25:22] == 4'd0);
            wr_lo_val = $urandom;
            wr_hi_val = r[26] ? 32'hFFFF_FFFF : $urandom;
            cycle("random R2 R4 R6 R9 R10");
        end
        finish_run();
    end
endmodule